// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block sits behind a ten-stage pipelined analog-to-digital converter and turns the stage decisions into a corrected output word. Stages 0 to 8 each report a redundant three-level decision. The last stage is a single comparator with no redundancy. One tick of `clk_i` is one half period of the sample clock. A sample moves one stage per tick, so stage k reports its decision for a sample k ticks after stage 0 does.

Each stage's decision passes through a delay line whose depth comes from that stage's arrival slot, so that all ten decisions for one sample line up. The aligned decisions are summed with one bit of overlap between neighbouring weights. A constant of half scale is added and the result is clamped to the output range. The sum then goes through a sum register and an output latch. The result is a straight offset binary word that stays exact when comparator offsets stay inside the redundancy margin.

Top module: `pipe_edc`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no input, `word_vld_o` is 0 and `word_o` is 0.
- R2: Each stage decision is coded 2'b00 = -1, 2'b01 = 0, 2'b10 = +1; 2'b11 is illegal with valid high. The word is 512 + sum over k = 0..8 of d_k * 2^(8-k), plus d_9. This is offset binary, and 512 is bipolar zero.
- R3: For a sample whose stage 0 decision is captured at clock edge e, stage k must be presented at edge e+k. The word and its valid appear after edge e+11, which is 5.5 sample-clock cycles later.
- R4: A new sample may start on every tick, and every sample yields its own word.
- R5: A sum above 1023 gives 1023. For example, all stages at +1 give 1024 before the clamp.
- R6: Decisions from an ideal quantizer reproduce every input code from 0 to 1023, so no code is missing.
- R7: Stages 0 to 8 may move each comparator threshold by up to 1/4 of the stage input range. The word is still exact and no code is missing.
- R8: A word is produced only if all ten stage valids for that sample were high. Otherwise `word_vld_o` stays low for that slot.
- R9: While `word_vld_o` is low, `word_o` keeps the last word produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stg_vld_i | input | 10 | Per-stage decision valid, bit k for stage k |
| stg_dec_i | input | 20 | Stage decisions, bits [2k+1:2k] for stage k |
| word_vld_o | output | 1 | Output word valid |
| word_o | output | 10 | Corrected offset binary word |

## Verification
All 1024 codes are first swept back to back from ideal stage decisions. This shows the alignment depths and the overlap weights at full throughput, and shows that every code is reached. The sweep is repeated with fixed per-stage threshold offsets and random idle slots. That pass separates true redundancy absorption from lucky ideal decisions, and it also shows the output latch holding during gaps. Random codes under a second offset set cover orderings that the ramp does not. Directed vectors cover the clamp at full scale, the bottom code, two different decision sets that must give the same word, and a sample with one stage valid missing.

// File: rtl/pipe_edc_pkg.sv
package pipe_edc_pkg;
  typedef enum logic [1:0] {
    DEC_NEG  = 2'b00,
    DEC_ZERO = 2'b01,
    DEC_POS  = 2'b10,
    DEC_BAD  = 2'b11
  } dec_e;

  function automatic int dec_val(input logic [1:0] d);
    case (d)
      DEC_NEG: return -1;
      DEC_POS: return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pipe_edc_delay.sv
module pipe_edc_delay #(
  parameter int DEPTH = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic [1:0] dec_i,
  output logic       vld_o,
  output logic [1:0] dec_o
);
  logic [DEPTH-1:0]      vld_sr;
  logic [DEPTH-1:0][1:0] dec_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_sr <= '0;
      dec_sr <= '0;
    end else begin
      vld_sr[0] <= vld_i;
      dec_sr[0] <= dec_i;
      for (int i = 1; i < DEPTH; i++) begin
        vld_sr[i] <= vld_sr[i-1];
        dec_sr[i] <= dec_sr[i-1];
      end
    end
  end

  assign vld_o = vld_sr[DEPTH-1];
  assign dec_o = dec_sr[DEPTH-1];

  // R2
  bad_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> (dec_i != 2'b11));
endmodule

// File: rtl/pipe_edc_merge.sv
module pipe_edc_merge
  import pipe_edc_pkg::*;
#(
  parameter int NSTAGE = 10
) (
  input  logic [2*NSTAGE-1:0] dec_i,
  input  logic [NSTAGE-1:0]   vld_i,
  output logic [NSTAGE-1:0]   word_o,
  output logic                vld_o
);
  localparam int OFFS = 1 << (NSTAGE - 1);
  localparam int MAXC = (1 << NSTAGE) - 1;

  int acc;
  int w;

  always_comb begin
    acc = OFFS;
    for (int k = 0; k < NSTAGE; k++) begin
      // last stage has no redundancy: same weight as its neighbour
      w   = (k == NSTAGE - 1) ? 1 : (1 << (NSTAGE - 2 - k));
      acc = acc + dec_val(dec_i[2*k +: 2]) * w;
    end
    if (acc > MAXC)   word_o = NSTAGE'(MAXC);
    else if (acc < 0) word_o = '0;
    else              word_o = acc[NSTAGE-1:0];
  end

  assign vld_o = &vld_i;
endmodule

// File: rtl/pipe_edc.sv
module pipe_edc #(
  parameter int NSTAGE = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NSTAGE-1:0]   stg_vld_i,
  input  logic [2*NSTAGE-1:0] stg_dec_i,
  output logic                word_vld_o,
  output logic [NSTAGE-1:0]   word_o
);
  logic [NSTAGE-1:0]   al_vld;
  logic [2*NSTAGE-1:0] al_dec;
  logic [NSTAGE-1:0]   mrg_word;
  logic                mrg_vld;
  logic [NSTAGE-1:0]   sum_q;
  logic                sum_vld_q;

  // depth = arrival slot distance to the last stage, plus one capture register
  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    pipe_edc_delay #(.DEPTH(NSTAGE - k)) u_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (stg_vld_i[k]),
      .dec_i (stg_dec_i[2*k +: 2]),
      .vld_o (al_vld[k]),
      .dec_o (al_dec[2*k +: 2])
    );
  end

  pipe_edc_merge #(.NSTAGE(NSTAGE)) u_merge (
    .dec_i (al_dec),
    .vld_i (al_vld),
    .word_o(mrg_word),
    .vld_o (mrg_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_vld_q <= 1'b0;
      sum_q     <= '0;
    end else begin
      sum_vld_q <= mrg_vld;
      sum_q     <= mrg_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= sum_vld_q;
      if (sum_vld_q) word_o <= sum_q;
    end
  end

  // R3
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg_vld_i[NSTAGE-1] |=> al_vld[NSTAGE-1]);

  // R3
  out_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_vld_q |=> word_vld_o);

  // R8
  partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&al_vld) |=> !sum_vld_q);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sum_vld_q |=> ($stable(word_o) && !word_vld_o));
endmodule

// File: tb/pipe_edc_bench.sv
module pipe_edc_bench;
  localparam int NS = 10;
  localparam int SLOTS = 2048;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NS-1:0]  stg_vld_i = '0;
  logic [2*NS-1:0] stg_dec_i = '0;
  logic           word_vld_o;
  logic [NS-1:0]  word_o;

  always #2.5ns clk_i = ~clk_i;

  pipe_edc #(.NSTAGE(NS)) u_pipe_edc (
    .clk_i(clk_i), .rst_ni(rst_ni), .stg_vld_i(stg_vld_i),
    .stg_dec_i(stg_dec_i), .word_vld_o(word_vld_o), .word_o(word_o));

  int n_chk = 0, n_bad = 0;
  int last_w = 0;
  bit          slot_v [SLOTS];
  logic [1:0]  slot_d [SLOTS][NS];
  logic [NS-1:0] slot_m [SLOTS];
  int          slot_e [SLOTS];
  string       slot_tag [SLOTS];
  bit          seen [1024];
  real         off_hi [NS], off_lo [NS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_offsets(input bit en);
    for (int k = 0; k < NS; k++) begin
      off_hi[k] = en ? real'(int'($urandom % 25) - 12) / 64.0 : 0.0;
      off_lo[k] = en ? real'(int'($urandom % 25) - 12) / 64.0 : 0.0;
    end
  endtask

  // behavioural stage model: ternary quantizer then residue 2v - d
  task automatic fill_ideal(input int s, input int c, input string tag);
    real v;
    int  d;
    v = (real'(c) - 511.5) / 512.0;
    for (int k = 0; k < NS - 1; k++) begin
      if (v >= 0.25 + off_hi[k]) d = 1;
      else if (v < -0.25 + off_lo[k]) d = -1;
      else d = 0;
      slot_d[s][k] = 2'(d + 1);
      v = 2.0 * v - real'(d);
    end
    slot_d[s][NS-1] = (v >= 0.0) ? 2'b01 : 2'b00;
    slot_v[s] = 1'b1; slot_m[s] = '1; slot_e[s] = c; slot_tag[s] = tag;
  endtask

  task automatic fill_dir(input int s, input logic [1:0] d0, input logic [1:0] d1,
                          input logic [1:0] rest, input logic [1:0] dl, input int e,
                          input string tag);
    for (int k = 0; k < NS; k++) slot_d[s][k] = rest;
    slot_d[s][0] = d0; slot_d[s][1] = d1; slot_d[s][NS-1] = dl;
    slot_v[s] = 1'b1; slot_m[s] = '1; slot_e[s] = e; slot_tag[s] = tag;
  endtask

  task automatic run_pass(input int n);
    int  s;
    bit  ev;
    int  t;
    for (int i = 0; i < n + 13; i++) begin
      @(negedge clk_i);
      s  = i - 12;
      ev = (s >= 0 && s < n) ? (slot_v[s] && (&slot_m[s])) : 1'b0;
      if (ev) begin
        chk(word_vld_o && (int'(word_o) == slot_e[s]), slot_tag[s],
            int'({word_vld_o, word_o}), 1024 + slot_e[s]);
        seen[slot_e[s]] = 1'b1;
        last_w = slot_e[s];
      end else begin
        chk(!word_vld_o && (int'(word_o) == last_w),
            (s >= 0 && s < n && slot_v[s]) ? slot_tag[s] : "R9",
            int'({word_vld_o, word_o}), last_w);
      end
      for (int k = 0; k < NS; k++) begin
        t = i - k;
        if (t >= 0 && t < n) begin
          stg_vld_i[k] = slot_v[t] & slot_m[t][k];
          stg_dec_i[2*k +: 2] = slot_v[t] ? slot_d[t][k] : 2'b01;
        end else begin
          stg_vld_i[k] = 1'b0;
          stg_dec_i[2*k +: 2] = 2'b01;
        end
      end
    end
  endtask

  task automatic check_missing(input string tag);
    int miss = 0;
    for (int c = 0; c < 1024; c++) if (!seen[c]) miss++;
    chk(miss == 0, tag, miss, 0);
    for (int c = 0; c < 1024; c++) seen[c] = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    chk(!word_vld_o && word_o == '0, "R1 reset", int'({word_vld_o, word_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!word_vld_o && word_o == '0, "R1 idle", int'({word_vld_o, word_o}), 0);

    // ramp, ideal, back to back
    set_offsets(1'b0);
    for (int c = 0; c < 1024; c++) fill_ideal(c, c, "R2 R3 R4 R6 ramp");
    run_pass(1024);
    check_missing("R6 missing codes");

    // ramp with threshold offsets and idle slots
    set_offsets(1'b1);
    begin
      int s = 0;
      for (int c = 0; c < 1024; c++) begin
        if ($urandom % 4 == 0) begin
          slot_v[s] = 1'b0; slot_m[s] = '1; slot_e[s] = 0; slot_tag[s] = "R9"; s++;
        end
        fill_ideal(s, c, "R7 offset ramp");
        s++;
      end
      run_pass(s);
    end
    check_missing("R7 missing codes");

    // random codes with another offset set
    set_offsets(1'b1);
    for (int s = 0; s < 300; s++) fill_ideal(s, int'($urandom % 1024), "R7 random");
    run_pass(300);

    // directed corners
    fill_dir(0, 2'b10, 2'b10, 2'b10, 2'b10, 1023, "R5 clamp");
    fill_dir(1, 2'b00, 2'b00, 2'b00, 2'b00, 0,    "R2 bottom");
    fill_dir(2, 2'b10, 2'b01, 2'b01, 2'b01, 768,  "R2 msb");
    fill_dir(3, 2'b10, 2'b00, 2'b01, 2'b01, 640,  "R2 overlap a");
    fill_dir(4, 2'b01, 2'b10, 2'b01, 2'b01, 640,  "R2 overlap b");
    fill_dir(5, 2'b10, 2'b10, 2'b10, 2'b01, 0,    "R8 partial");
    slot_m[5] = 10'b11_1110_1111;
    slot_v[6] = 1'b0; slot_m[6] = '1; slot_e[6] = 0; slot_tag[6] = "R9";
    fill_dir(7, 2'b01, 2'b01, 2'b01, 2'b10, 513,  "R2 last stage");
    fill_dir(8, 2'b01, 2'b01, 2'b01, 2'b01, 512,  "R2 bipolar zero");
    run_pass(9);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule